// File: doc/BRIEF.md
# Four-Function Adder-Subtractor ALU

This block is a purely combinational arithmetic unit for small two's-complement operands. A two-bit opcode selects one of four operations: reverse subtraction (B minus A), forward subtraction (A minus B), addition, and negation of A. All four operations run on a single ripple-carry chain of full-adder cells. A front-end conditioning stage feeds that chain. It can invert A or B, force the second adder input to zero, and assert the carry-in. This produces each function as X + Y + cin.

The result wraps modulo 2^W. Two flags come with it. The first is the unsigned carry out of the top stage. The second is a signed overflow flag, which is the XOR of the carries into and out of the most significant cell. The block holds no state and uses no clock. A surrounding pipeline registers its inputs and outputs as it needs.

Top module: `alu4_addsub`

## Requirements
- R1: With op_i = 0, d_o equals (b_i - a_i) mod 2^W.
- R2: With op_i = 1, d_o equals (a_i - b_i) mod 2^W.
- R3: With op_i = 2, d_o equals (a_i + b_i) mod 2^W.
- R4: With op_i = 3, d_o equals (0 - a_i) mod 2^W, and b_i has no effect on any output.
- R5: The value of carry_o depends on the operation:
  - For addition, carry_o is 1 exactly when the unsigned sum is at least 2^W.
  - For either subtraction, carry_o is 1 exactly when the unsigned minuend is greater than or equal to the unsigned subtrahend, meaning no borrow.
  - For negation, carry_o is 1 exactly when a_i is zero.
- R6: ovf_o is 1 exactly when the true signed result, with operands read as W-bit two's complement, lies outside [-2^(W-1), 2^(W-1)-1].
- R7: Negating the most negative value (a_i = 1000 for W = 4) returns 1000, with ovf_o = 1 and carry_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W (4) | Operand A, two's complement |
| b_i | input | W (4) | Operand B, two's complement |
| op_i | input | 2 | Operation: 0 = B-A, 1 = A-B, 2 = A+B, 3 = -A |
| d_o | output | W (4) | Result, modulo 2^W |
| carry_o | output | 1 | Carry out of the most significant cell |
| ovf_o | output | 1 | Signed overflow |

## Verification
Each opcode is swept over every pair of operands. This covers every carry pattern through the chain and every signed-overflow boundary. A single asymmetric pair (a = 3, b = 5) is applied under both subtraction codes, which tells a swapped inversion apart from a correct one. Negation is tried with varying b_i to show that the forced-zero path ignores B. The minimum value 1000 separates correct overflow logic from a flag that only compares the operand and result signs. The all-zero input shows that a subtraction carry-in produces carry_o = 1 when there is no borrow.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
  typedef enum logic [1:0] {
    OP_RSUB = 2'd0,
    OP_SUB  = 2'd1,
    OP_ADD  = 2'd2,
    OP_NEG  = 2'd3
  } alu_op_e;
endpackage

// File: rtl/alu4_fa.sv
module alu4_fa (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic xy_x;
  assign xy_x = x_i ^ y_i;
  assign s_o  = xy_x ^ c_i;
  // majority of three
  assign c_o  = (x_i & y_i) | (x_i & c_i) | (y_i & c_i);
endmodule

// File: rtl/alu4_opnd_cond.sv
module alu4_opnd_cond
  import alu4_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   op_i,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o,
  output logic         cin_o
);
  logic inv_a, inv_b, zero_b;
  logic [W-1:0] b_gated;

  assign inv_a  = (op_i == OP_RSUB) | (op_i == OP_NEG);
  assign inv_b  = (op_i == OP_SUB);
  assign zero_b = (op_i == OP_NEG);
  assign cin_o  = (op_i != OP_ADD);

  assign b_gated = b_i & ~{W{zero_b}};
  assign x_o     = a_i ^ {W{inv_a}};
  assign y_o     = b_gated ^ {W{inv_b}};
endmodule

// File: rtl/alu4_ripple.sv
module alu4_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         c_msb_in_o
);
  logic [W:0] c;
  assign c[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_cell
    alu4_fa u_fa (
      .x_i (x_i[i]),
      .y_i (y_i[i]),
      .c_i (c[i]),
      .s_o (sum_o[i]),
      .c_o (c[i+1])
    );
  end

  assign cout_o     = c[W];
  assign c_msb_in_o = c[W-1];
endmodule

// File: rtl/alu4_addsub.sv
module alu4_addsub #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   op_i,
  output logic [W-1:0] d_o,
  output logic         carry_o,
  output logic         ovf_o
);
  logic [W-1:0] x, y;
  logic         cin, c_top_in;

  alu4_opnd_cond #(.W(W)) u_cond (
    .a_i   (a_i),
    .b_i   (b_i),
    .op_i  (op_i),
    .x_o   (x),
    .y_o   (y),
    .cin_o (cin)
  );

  alu4_ripple #(.W(W)) u_add (
    .x_i        (x),
    .y_i        (y),
    .cin_i      (cin),
    .sum_o      (d_o),
    .cout_o     (carry_o),
    .c_msb_in_o (c_top_in)
  );

  assign ovf_o = c_top_in ^ carry_o;
endmodule

// File: rtl/alu4_addsub_chk.sv
module alu4_addsub_chk
  import alu4_pkg::*;
#(
  parameter int W = 4
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [1:0]   op_i,
  input logic [W-1:0] d_o,
  input logic         carry_o,
  input logic         ovf_o
);
  localparam int SMAX = (1 << (W-1)) - 1;
  localparam int SMIN = -(1 << (W-1));
  localparam int UMOD = 1 << W;

  int sa, sb, tr, ua, ub;
  logic [W-1:0] exp_d;
  logic exp_c, exp_v;

  always_comb begin
    sa = int'($signed(a_i));
    sb = int'($signed(b_i));
    ua = int'(a_i);
    ub = int'(b_i);
    case (op_i)
      OP_RSUB: begin tr = sb - sa; exp_c = (ub >= ua); end
      OP_SUB:  begin tr = sa - sb; exp_c = (ua >= ub); end
      OP_ADD:  begin tr = sa + sb; exp_c = (ua + ub >= UMOD); end
      default: begin tr = -sa;     exp_c = (ua == 0); end
    endcase
    exp_d = tr[W-1:0];
    exp_v = (tr > SMAX) || (tr < SMIN);
  end

  always_comb begin
    if (op_i == OP_RSUB) a_r1_rsub: assert (d_o == exp_d) else $error("R1 rsub");
    if (op_i == OP_SUB)  a_r2_sub:  assert (d_o == exp_d) else $error("R2 sub");
    if (op_i == OP_ADD)  a_r3_add:  assert (d_o == exp_d) else $error("R3 add");
    if (op_i == OP_NEG)  a_r4_neg:  assert (d_o == exp_d) else $error("R4 neg");
    a_r5_carry: assert (carry_o == exp_c) else $error("R5 carry");
    a_r6_ovf:   assert (ovf_o == exp_v) else $error("R6 ovf");
    if (op_i == OP_NEG && a_i == {1'b1, {(W-1){1'b0}}})
      a_r7_neg_min: assert (d_o == a_i && ovf_o && !carry_o) else $error("R7 neg min");
  end
endmodule

bind alu4_addsub alu4_addsub_chk #(.W(W)) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .op_i    (op_i),
  .d_o     (d_o),
  .carry_o (carry_o),
  .ovf_o   (ovf_o)
);

// File: tb/alu4_addsub_test.sv
module alu4_addsub_test;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [1:0] op = 2'd0;
  logic [W-1:0] d;
  logic carry, ovf;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  alu4_addsub #(.W(W)) uut (
    .a_i(a), .b_i(b), .op_i(op), .d_o(d), .carry_o(carry), .ovf_o(ovf)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s a=%0d b=%0d op=%0d actual=%0d expected=%0d", req, a, b, op, act, exp);
    end
  endtask

  task automatic apply(input int av, input int bv, input int opv);
    @(posedge clk); #1;
    a = av[W-1:0]; b = bv[W-1:0]; op = opv[1:0];
    @(negedge clk);
  endtask

  // independent arithmetic model
  task automatic model(input int av, input int bv, input int opv,
                       output int ed, output int ec, output int ev);
    int sa, sb, t;
    sa = (av >= 8) ? av - 16 : av;
    sb = (bv >= 8) ? bv - 16 : bv;
    case (opv)
      0: begin t = sb - sa; ec = (bv >= av) ? 1 : 0; end
      1: begin t = sa - sb; ec = (av >= bv) ? 1 : 0; end
      2: begin t = sa + sb; ec = (av + bv >= 16) ? 1 : 0; end
      default: begin t = -sa; ec = (av == 0) ? 1 : 0; end
    endcase
    ed = t & 15;
    ev = (t > 7 || t < -8) ? 1 : 0;
  endtask

  task automatic t_reset_state();
    check("R1 reset d", int'(d), 0);
    check("R5 reset carry", int'(carry), 1);
    check("R6 reset ovf", int'(ovf), 0);
  endtask

  task automatic t_sweep(input int opv, input string tag);
    int ed, ec, ev;
    for (int ia = 0; ia < 16; ia++)
      for (int ib = 0; ib < 16; ib++) begin
        apply(ia, ib, opv);
        model(ia, ib, opv, ed, ec, ev);
        check(tag, int'(d), ed);
        check("R5 carry", int'(carry), ec);
        check("R6 ovf", int'(ovf), ev);
      end
  endtask

  task automatic t_order();
    apply(3, 5, 0); check("R1 order b-a", int'(d), 2);
    apply(3, 5, 1); check("R2 order a-b", int'(d), 14);
  endtask

  task automatic t_neg_ignores_b();
    for (int ib = 0; ib < 16; ib++) begin
      apply(6, ib, 3);
      check("R4 b ignored d", int'(d), 10);
      check("R4 b ignored carry", int'(carry), 0);
      check("R4 b ignored ovf", int'(ovf), 0);
    end
  endtask

  task automatic t_neg_min();
    apply(8, 5, 3);
    check("R7 neg min d", int'(d), 8);
    check("R7 neg min ovf", int'(ovf), 1);
    check("R7 neg min carry", int'(carry), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_order();
    t_sweep(0, "R1 rsub d");
    t_sweep(1, "R2 sub d");
    t_sweep(2, "R3 add d");
    t_sweep(3, "R4 neg d");
    t_neg_ignores_b();
    t_neg_min();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule